// File: doc/BRIEF.md
# Dual-Polynomial Serial CRC Unit for a Single-Wire Slave

This unit computes two cyclic redundancy checks over a serial bit stream. Bits arrive one per strobe, least significant bit first. A mode input sends each bit to one of two lanes. In identity mode the bits go to an 8-bit lane that checks a 64-bit device identity. The first 56 bits are data and feed the 8-bit CRC. The last 8 bits are the stored check byte, which is compared bit by bit with the computed value in true form. Once all 64 bits are in, a done flag and a match flag report the result.

In memory mode the bits go to a 16-bit lane. This lane covers page reads, log reads and scratchpad transfers. The running value is available in true form for checking against received data. Its bitwise complement is available as the value to transmit. A synchronous clear puts both lanes and the identity tracker back to their start state.

Top module: `owcrc_unit`

## Requirements
- R1: When `clr_i` is sampled high, both CRC registers become zero and `rom_done_o` and `rom_match_o` become low on that edge. Clear takes priority over `bit_vld_i`.
- R2: In identity mode (`mode_i`=0), each valid bit among the first 56 after a clear updates `crc8_o` in reflected form with polynomial x^8+x^5+x^4+1 (mask 0x8C). The update is: shift right by one, then XOR the mask when the old bit 0 differs from the input bit.
- R3: In identity mode, `crc8_o` holds its value from bit 56 on. Valid bits 57 to 64 are compared in order with bits 0 through 7 of `crc8_o`.
- R4: `rom_done_o` rises on the edge that takes the 64th identity-mode bit. `rom_match_o` is high exactly when done is high and all 8 compared bits were equal.
- R5: After `rom_done_o` is high, further identity-mode bits change neither `crc8_o`, `rom_done_o` nor `rom_match_o` until the next clear.
- R6: In memory mode (`mode_i`=1), every valid bit updates `crc16_o` in reflected form with polynomial x^16+x^15+x^2+1 (mask 0xA001). Memory-mode bits leave `crc8_o` and the identity tracker untouched.
- R7: `crc16_tx_o` is always the bitwise complement of `crc16_o`.
- R8: A cycle with `bit_vld_i` and `clr_i` both low changes no output.
- R9: All outputs are registered. They take their new value on the same rising edge that samples the valid bit or the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of both lanes and the tracker |
| bit_vld_i | input | 1 | Strobe marking `bit_i` as valid |
| bit_i | input | 1 | Serial data bit, least significant bit first |
| mode_i | input | 1 | 0 = identity (8-bit) lane, 1 = memory (16-bit) lane |
| crc8_o | output | 8 | Running 8-bit CRC, true form |
| crc16_o | output | 16 | Running 16-bit CRC, true form |
| crc16_tx_o | output | 16 | Complement of the 16-bit CRC, for transmission |
| rom_done_o | output | 1 | All 64 identity bits received |
| rom_match_o | output | 1 | Received check byte equals computed CRC |

## Verification
The assertions assume that `mode_i` and `bit_i` are known whenever `bit_vld_i` is high. They also assume that a clear is issued before each new identity stream, because the tracker counts bits from the last clear. The stimulus always clears before an identity stream. It inserts idle cycles between bits and switches to memory-mode bits in the middle of an identity stream. It also issues one clear while a bit is valid. This covers the hold, isolation and priority rules without breaking these assumptions.

// File: rtl/owcrc_pkg.sv
package owcrc_pkg;
    typedef enum logic {
        MODE_ROM = 1'b0,
        MODE_MEM = 1'b1
    } crc_mode_e;

    localparam int unsigned OW_ROM_BITS = 64;
    localparam int unsigned OW_CRC8_W   = 8;
    localparam int unsigned OW_CRC16_W  = 16;
endpackage

// File: rtl/owcrc_lane.sv
module owcrc_lane #(
    parameter int unsigned W    = 8,
    parameter logic [W-1:0] POLY = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    typedef struct packed {
        logic [W-1:0] crc;
    } lane_t;

    lane_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            s_d.crc = '0;
        end else if (en_i) begin
            s_d.crc = s_q.crc >> 1;
            if (s_q.crc[0] ^ bit_i) begin
                s_d.crc = s_d.crc ^ POLY;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign crc_o = s_q.crc;

    // R1: a clear always leaves the lane at zero
    a_r1_lane_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (crc_o == '0));

    // R8: no enable and no clear, the value holds
    a_r8_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !en_i) |=> $stable(crc_o));

    // R2 / R6: a non-feedback step is a plain right shift
    a_r2_r6_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i && (crc_o[0] == bit_i)) |=> (crc_o == ($past(crc_o) >> 1)));
endmodule

// File: rtl/owcrc_rom_track.sv
module owcrc_rom_track #(
    parameter int unsigned ROM_BITS = 64,
    parameter int unsigned CRC_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             vld_i,
    input  logic             bit_i,
    input  logic [CRC_W-1:0] crc_i,
    output logic             upd_o,
    output logic             done_o,
    output logic             match_o
);
    localparam int unsigned DATA_BITS = ROM_BITS - CRC_W;
    localparam int unsigned CNT_W     = $clog2(ROM_BITS + 1);
    localparam int unsigned IDX_W     = (CRC_W > 1) ? $clog2(CRC_W) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             miss;
    } trk_t;

    trk_t s_d, s_q;

    logic             in_data;
    logic             full;
    logic [CNT_W-1:0] off;
    logic [IDX_W-1:0] idx;

    always_comb begin
        in_data = (s_q.cnt < CNT_W'(DATA_BITS));
        full    = (s_q.cnt == CNT_W'(ROM_BITS));
        off     = s_q.cnt - CNT_W'(DATA_BITS);
        idx     = off[IDX_W-1:0];
        upd_o   = vld_i && !clr_i && in_data;

        s_d = s_q;
        if (clr_i) begin
            s_d = '0;
        end else if (vld_i && !full) begin
            s_d.cnt = s_q.cnt + 1'b1;
            if (!in_data && (bit_i != crc_i[idx])) begin
                s_d.miss = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done_o  = full;
    assign match_o = full && !s_q.miss;

    // R3: computed CRC stays frozen while the check byte arrives
    a_r3_crc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_data && !clr_i) |=> $stable(crc_i));

    // R4: the bit counter never passes the identity length
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(ROM_BITS));

    // R5: after completion, result holds until cleared
    a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clr_i) |=> (done_o && $stable(match_o)));

    // R1: clear drops done and match
    a_r1_trk_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!done_o && !match_o));
endmodule

// File: rtl/owcrc_unit.sv
module owcrc_unit
    import owcrc_pkg::*;
#(
    parameter int unsigned ROM_BITS = OW_ROM_BITS,
    parameter int unsigned CRC8_W   = OW_CRC8_W,
    parameter int unsigned CRC16_W  = OW_CRC16_W,
    parameter logic [CRC8_W-1:0]  POLY8  = 8'h8C,
    parameter logic [CRC16_W-1:0] POLY16 = 16'hA001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               bit_vld_i,
    input  logic               bit_i,
    input  logic               mode_i,
    output logic [CRC8_W-1:0]  crc8_o,
    output logic [CRC16_W-1:0] crc16_o,
    output logic [CRC16_W-1:0] crc16_tx_o,
    output logic               rom_done_o,
    output logic               rom_match_o
);
    crc_mode_e mode;
    logic      rom_vld;
    logic      mem_vld;
    logic      rom_upd;

    always_comb begin
        mode    = crc_mode_e'(mode_i);
        rom_vld = bit_vld_i && (mode == MODE_ROM);
        mem_vld = bit_vld_i && (mode == MODE_MEM);
    end

    owcrc_rom_track #(
        .ROM_BITS (ROM_BITS),
        .CRC_W    (CRC8_W)
    ) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_i),
        .vld_i   (rom_vld),
        .bit_i   (bit_i),
        .crc_i   (crc8_o),
        .upd_o   (rom_upd),
        .done_o  (rom_done_o),
        .match_o (rom_match_o)
    );

    owcrc_lane #(
        .W    (CRC8_W),
        .POLY (POLY8)
    ) u_lane8 (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_i),
        .en_i  (rom_upd),
        .bit_i (bit_i),
        .crc_o (crc8_o)
    );

    owcrc_lane #(
        .W    (CRC16_W),
        .POLY (POLY16)
    ) u_lane16 (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_i),
        .en_i  (mem_vld),
        .bit_i (bit_i),
        .crc_o (crc16_o)
    );

    assign crc16_tx_o = ~crc16_o;

    // R6: memory-mode bits leave the identity side untouched
    a_r6_mem_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_vld && !clr_i) |=> ($stable(crc8_o) && $stable(rom_done_o) && $stable(rom_match_o)));

    // R6: identity-mode bits leave the memory lane untouched
    a_r6_rom_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_vld && !clr_i) |=> $stable(crc16_o));
endmodule

// File: tb/tb_owcrc_unit.sv
module tb_owcrc_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_i = 1'b0;
    logic        bit_vld_i = 1'b0;
    logic        bit_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [7:0]  crc8_o;
    logic [15:0] crc16_o;
    logic [15:0] crc16_tx_o;
    logic        rom_done_o;
    logic        rom_match_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // behavioural reference state
    int ref8 = 0;
    int ref16 = 0;
    int rcnt = 0;
    bit rmiss = 0;

    owcrc_unit dut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .bit_vld_i(bit_vld_i),
        .bit_i(bit_i), .mode_i(mode_i), .crc8_o(crc8_o), .crc16_o(crc16_o),
        .crc16_tx_o(crc16_tx_o), .rom_done_o(rom_done_o), .rom_match_o(rom_match_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare_all();
        bit edone;
        edone = (rcnt == 64);
        chk("R2/R3 crc8", int'(crc8_o), ref8);
        chk("R6 crc16", int'(crc16_o), ref16);
        chk("R7 tx", int'(crc16_tx_o), (~ref16) & 'hFFFF);
        chk("R4 done", int'(rom_done_o), int'(edone));
        chk("R4 match", int'(rom_match_o), int'(edone && !rmiss));
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input bit c, input bit v, input bit m, input bit b);
        clr_i = c; bit_vld_i = v; mode_i = m; bit_i = b;
        @(posedge clk);
        if (c) begin
            ref8 = 0; ref16 = 0; rcnt = 0; rmiss = 0;
        end else if (v) begin
            if (!m) begin
                if (rcnt < 56) begin
                    if (((ref8 ^ int'(b)) & 1) != 0) ref8 = (ref8 / 2) ^ 'h8C;
                    else                            ref8 = ref8 / 2;
                    rcnt++;
                end else if (rcnt < 64) begin
                    if (int'(b) != ((ref8 >> (rcnt - 56)) & 1)) rmiss = 1;
                    rcnt++;
                end
            end else begin
                if (((ref16 ^ int'(b)) & 1) != 0) ref16 = (ref16 / 2) ^ 'hA001;
                else                             ref16 = ref16 / 2;
            end
        end
        @(negedge clk);
        clr_i = 0; bit_vld_i = 0;
        compare_all();
    endtask

    task automatic rom_stream(input int flip_pos);
        int sent;
        sent = 0;
        step(1, 0, 0, 0);                      // R1 clear before the stream
        while (sent < 56) begin
            if ($urandom_range(0, 3) == 0) step(0, 0, 0, 1);   // R8 idle gap
            else begin step(0, 1, 0, 1'($urandom_range(0, 1))); sent++; end
        end
        for (int i = 0; i < 8; i++) begin      // R3 check byte, LSB first
            bit bb;
            bb = 1'((ref8 >> i) & 1);
            if (i == flip_pos) bb = ~bb;
            step(0, 1, 0, bb);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();                         // reset state, R1

        rom_stream(-1);                        // R4 good identity
        chk("R4 match good", int'(rom_match_o), 1);
        for (int i = 0; i < 6; i++) step(0, 1, 0, 1'(i));   // R5 extra bits ignored
        chk("R5 done held", int'(rom_done_o), 1);

        rom_stream(3);                         // R4 corrupted check byte
        chk("R4 match bad", int'(rom_match_o), 0);

        step(1, 0, 0, 0);                      // R6 memory stream
        for (int i = 0; i < 96; i++) step(0, 1, 1, 1'($urandom_range(0, 1)));

        step(1, 0, 0, 0);                      // R6 interleaved modes
        for (int i = 0; i < 20; i++) step(0, 1, 0, 1'($urandom_range(0, 1)));
        for (int i = 0; i < 24; i++) step(0, 1, 1, 1'($urandom_range(0, 1)));
        for (int i = 0; i < 36; i++) step(0, 1, 0, 1'($urandom_range(0, 1)));
        for (int i = 0; i < 8; i++) step(0, 1, 0, 1'((ref8 >> i) & 1));
        chk("R6 match after interleave", int'(rom_match_o), 1);

        for (int i = 0; i < 10; i++) step(0, 1, 1, 1'b1);
        step(1, 1, 1, 1'b1);                   // R1 clear beats valid
        chk("R1 clear priority", int'(crc16_o), 0);
        for (int i = 0; i < 5; i++) step(0, 0, 1, 1'b1);    // R8 no strobe
        chk("R9 registered idle", int'(crc16_o), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule